// File: doc/BRIEF.md
# AES-128 Round Key Expander

This block turns a 128-bit cipher key into the eleven round keys that an AES-128 cipher and its inverse need. After reset is released it derives one 32-bit schedule word per clock and keeps every word in an internal register file. Forty clocks after the release all 44 words are present, and a sticky ready flag rises. The surrounding datapath must not feed data blocks into the cipher rounds until that flag is high.

The round keys are read through a combinational random-access port. A 4-bit index selects a round key, and the selected key appears in the same cycle. A forward cipher walks the index upward from 0. An inverse cipher walks it downward from 10 to 0. The read port carries no stream and has no valid/ready handshake, so back-pressure does not apply: any index may be presented in any cycle, and the result is meaningful once ready is high.

The key is sampled while reset is high. Each new reset clears ready and starts a fresh expansion from whatever key is applied at that moment.

Top module: `aes_key_expander`

## Requirements
- R1: `ready` is 0 while `rst` is high and remains 0 for the first 39 rising edges after `rst` falls. It is 1 after the 40th rising edge.
- R2: Once `ready` is 1 it stays 1, and the round keys stay unchanged, until `rst` is raised again.
- R3: Round key 0 (index 0) equals the key that was applied during reset.
- R4: Round key r (1..10) is the 128-bit value {w[4r], w[4r+1], w[4r+2], w[4r+3]}, with w[4r] in bits 127:96. The words w[0..3] are the key, with w[0] = key[127:96]. For i in 4..43 with i mod 4 = 0, w[i] = w[i-4] ^ SubWord(RotWord(w[i-1])) ^ {Rcon[i/4], 24'h0}. RotWord rotates the word left by one byte. The Rcon sequence is 01,02,04,08,10,20,40,80,1B,36. For all other i, w[i] = w[i-4] ^ w[i-1]. For key 2B7E151628AED2A6ABF7158809CF4F3C, round 1 is A0FAFE1788542CB123A339392A6C7605 and round 10 is D014F9A8C9EE2589E13F0CC8B6630CA6.
- R5: An index from 11 to 15 reads as all zeros.
- R6: Changes on `key` after `rst` falls have no effect on any round key produced by that expansion.
- R7: Raising `rst` at any point, including in the middle of an expansion, clears `ready`. The expansion then restarts with the currently applied key and again takes 40 cycles.
- R8: `rd_key` follows `rd_idx` combinationally, with no clock edge between a change of index and the matching round key.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high; key is captured while high |
| key | input | 128 | Cipher key |
| rd_idx | input | 4 | Round key index, 0 to 10 |
| rd_key | output | 128 | Selected round key |
| ready | output | 1 | All round keys computed |

## Verification
Every schedule word is built from the words before it. A single wrong word, a wrong S-box entry or a mistimed Rcon step therefore corrupts that round key and every later one, and it is visible at the read port as soon as `ready` rises. Round 10 is the most sensitive observation point. An off-by-one in the word counter instead shows up as `ready` rising a cycle early or late, which is observable exactly at the 40-cycle boundary. A stale capture register would show the old key in round 0 after a reset taken in the middle of an expansion.

// File: rtl/aes_ks_pkg.sv
package aes_ks_pkg;
  localparam int NK     = 4;
  localparam int NR     = 10;
  localparam int NW     = NK * (NR + 1);
  localparam int WORD_W = 32;
  localparam int KEY_W  = NK * WORD_W;
  localparam int RIDX_W = 4;
  localparam int WIDX_W = $clog2(NW + 1);

  typedef logic [WORD_W-1:0] word_t;

  function automatic logic [7:0] gf_xtime(input logic [7:0] b);
    return {b[6:0], 1'b0} ^ (b[7] ? 8'h1b : 8'h00);
  endfunction
endpackage

// File: rtl/aes_ks_sbox.sv
module aes_ks_sbox
  import aes_ks_pkg::*;
(
  input  logic [7:0] a,
  output logic [7:0] s
);
  function automatic logic [7:0] gf_mul(input logic [7:0] x, input logic [7:0] y);
    logic [7:0] acc;
    logic [7:0] sh;
    acc = 8'h00;
    sh  = x;
    for (int i = 0; i < 8; i++) begin
      if (y[i]) acc = acc ^ sh;
      sh = gf_xtime(sh);
    end
    return acc;
  endfunction

  // x^254 is the multiplicative inverse (and maps 0 to 0)
  function automatic logic [7:0] gf_inv(input logic [7:0] x);
    logic [7:0] sq;
    logic [7:0] r;
    sq = x;
    r  = 8'h01;
    for (int k = 1; k < 8; k++) begin
      sq = gf_mul(sq, sq);
      r  = gf_mul(r, sq);
    end
    return r;
  endfunction

  logic [7:0] inv;

  always_comb begin
    inv = gf_inv(a);
    s   = inv ^ {inv[6:0], inv[7]} ^ {inv[5:0], inv[7:6]}
              ^ {inv[4:0], inv[7:5]} ^ {inv[3:0], inv[7:4]} ^ 8'h63;
  end

  // R4: the substitution has neither fixed nor complemented-fixed points
  always_comb begin
    if (!$isunknown(a)) begin
      a_r4_no_fixed_point: assert (s != a && s != ~a);
    end
  end
endmodule

// File: rtl/aes_ks_step.sv
module aes_ks_step
  import aes_ks_pkg::*;
(
  input  word_t      back4,
  input  word_t      prev,
  input  logic       head,
  input  logic [7:0] rcon,
  output word_t      nxt
);
  localparam int NB = WORD_W / 8;

  word_t rot;
  word_t sub;

  assign rot = {prev[WORD_W-9:0], prev[WORD_W-1:WORD_W-8]};

  for (genvar g = 0; g < NB; g++) begin : g_sub
    aes_ks_sbox u_sbox (
      .a (rot[8*g +: 8]),
      .s (sub[8*g +: 8])
    );
  end

  always_comb begin
    if (head) nxt = back4 ^ sub ^ {rcon, {(WORD_W-8){1'b0}}};
    else      nxt = back4 ^ prev;
  end
endmodule

// File: rtl/aes_ks_store.sv
module aes_ks_store
  import aes_ks_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              ready,
  input  logic              ld_en,
  input  logic [KEY_W-1:0]  ld_key,
  input  logic              wr_en,
  input  logic [WIDX_W-1:0] wr_idx,
  input  word_t             wr_data,
  input  logic [RIDX_W-1:0] rd_idx,
  output logic [KEY_W-1:0]  rd_key
);
  logic [NW-1:0][WORD_W-1:0] w;
  logic [WIDX_W-1:0]         base;

  always_ff @(posedge clk) begin
    if (ld_en) begin
      for (int n = 0; n < NK; n++) w[n] <= ld_key[KEY_W-1-WORD_W*n -: WORD_W];
    end else if (wr_en) begin
      w[wr_idx] <= wr_data;
    end
  end

  always_comb begin
    rd_key = '0;
    base   = WIDX_W'(rd_idx) * WIDX_W'(NK);
    if (rd_idx <= RIDX_W'(NR)) begin
      for (int n = 0; n < NK; n++)
        rd_key[KEY_W-1-WORD_W*n -: WORD_W] = w[base + WIDX_W'(n)];
    end
  end

  // R3: the first four words hold the key captured on the previous edge
  a_r3_key_loaded: assert property (@(posedge clk)
    ld_en |=> ({w[0], w[1], w[2], w[3]} == $past(ld_key)));

  // R4: generated words land only in the schedule range above the key
  a_r4_write_range: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> (wr_idx >= WIDX_W'(NK) && wr_idx < WIDX_W'(NW)));

  // R2: storage is frozen once the schedule is complete
  a_r2_frozen_when_ready: assert property (@(posedge clk) disable iff (rst)
    ready |=> $stable(w));

  // R5: indexes past the last round read as zero
  a_r5_out_of_range_zero: assert property (@(posedge clk) disable iff (rst)
    (rd_idx > RIDX_W'(NR)) |-> (rd_key == '0));
endmodule

// File: rtl/aes_key_expander.sv
module aes_key_expander
  import aes_ks_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [KEY_W-1:0]  key,
  input  logic [RIDX_W-1:0] rd_idx,
  output logic [KEY_W-1:0]  rd_key,
  output logic              ready
);
  localparam int GEN_CYCLES = NW - NK;

  logic [NK-1:0][WORD_W-1:0] win;
  logic [WIDX_W-1:0]         cnt;
  logic [7:0]                rcon;
  logic                      head;
  logic                      wr_en;
  word_t                     nxt;

  assign head  = (cnt % WIDX_W'(NK)) == '0;
  assign wr_en = !rst && !ready;

  aes_ks_step u_step (
    .back4 (win[0]),
    .prev  (win[NK-1]),
    .head  (head),
    .rcon  (rcon),
    .nxt   (nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt   <= WIDX_W'(NK);
      rcon  <= 8'h01;
      ready <= 1'b0;
      for (int n = 0; n < NK; n++) win[n] <= key[KEY_W-1-WORD_W*n -: WORD_W];
    end else if (!ready) begin
      for (int n = 0; n < NK-1; n++) win[n] <= win[n+1];
      win[NK-1] <= nxt;
      cnt       <= cnt + 1'b1;
      if (head) rcon <= gf_xtime(rcon);
      if (cnt == WIDX_W'(NW-1)) ready <= 1'b1;
    end
  end

  aes_ks_store u_store (
    .clk     (clk),
    .rst     (rst),
    .ready   (ready),
    .ld_en   (rst),
    .ld_key  (key),
    .wr_en   (wr_en),
    .wr_idx  (cnt),
    .wr_data (nxt),
    .rd_idx  (rd_idx),
    .rd_key  (rd_key)
  );

  // Independent cycle counter since reset release, for the timing check
  logic [WIDX_W-1:0] since_rst;
  always_ff @(posedge clk) begin
    if (rst) since_rst <= '0;
    else if (since_rst < WIDX_W'(GEN_CYCLES)) since_rst <= since_rst + 1'b1;
  end

  // R1: ready rises exactly when the 40th generation cycle completes
  a_r1_ready_timing: assert property (@(posedge clk) disable iff (rst)
    ready == (since_rst == WIDX_W'(GEN_CYCLES)));

  // R2: ready is sticky until the next reset
  a_r2_ready_sticky: assert property (@(posedge clk) disable iff (rst)
    ready |=> ready);

  // R7: any reset clears ready on the following cycle
  a_r7_reset_clears: assert property (@(posedge clk)
    rst |=> !ready);

  // R4: round constant is a legal value whenever it is consumed
  a_r4_rcon_legal: assert property (@(posedge clk) disable iff (rst)
    (wr_en && head) |-> ($onehot(rcon) || rcon == 8'h1b || rcon == 8'h36));
endmodule

// File: tb/tb_aes_key_expander.sv
`timescale 1ns/1ps
module tb_aes_key_expander;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [127:0] key = '0;
  logic [3:0]   rd_idx = '0;
  logic [127:0] rd_key;
  logic         ready;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 0;

  logic [7:0] sb [256];
  logic [7:0] rc_tab [10] = '{8'h01, 8'h02, 8'h04, 8'h08, 8'h10,
                              8'h20, 8'h40, 8'h80, 8'h1b, 8'h36};

  always #2.5 clk = ~clk;

  aes_key_expander dut (
    .clk    (clk),
    .rst    (rst),
    .key    (key),
    .rd_idx (rd_idx),
    .rd_key (rd_key),
    .ready  (ready)
  );

  function automatic logic [7:0] rl(input logic [7:0] v, input int k);
    return (v << k) | (v >> (8 - k));
  endfunction

  // S-box table by walking generator 3 and its inverse
  task automatic build_sbox();
    logic [7:0] p, q, x;
    p = 8'h01;
    q = 8'h01;
    do begin
      p = p ^ {p[6:0], 1'b0} ^ (p[7] ? 8'h1b : 8'h00);
      q = q ^ {q[6:0], 1'b0};
      q = q ^ {q[5:0], 2'b00};
      q = q ^ {q[3:0], 4'h0};
      if (q[7]) q = q ^ 8'h09;
      x = q ^ rl(q, 1) ^ rl(q, 2) ^ rl(q, 3) ^ rl(q, 4);
      sb[p] = x ^ 8'h63;
    end while (p != 8'h01);
    sb[0] = 8'h63;
  endtask

  function automatic logic [127:0] ref_round(input logic [127:0] k, input int r);
    logic [31:0] w [44];
    logic [31:0] t;
    for (int i = 0; i < 4; i++) w[i] = k[127-32*i -: 32];
    for (int i = 4; i < 44; i++) begin
      t = w[i-1];
      if (i % 4 == 0) begin
        t = {t[23:0], t[31:24]};
        t = {sb[t[31:24]], sb[t[23:16]], sb[t[15:8]], sb[t[7:0]]};
        t = t ^ {rc_tab[i/4 - 1], 24'h0};
      end
      w[i] = w[i-4] ^ t;
    end
    return {w[4*r], w[4*r+1], w[4*r+2], w[4*r+3]};
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Assert reset with key k for two edges, release at a falling edge
  task automatic start(input logic [127:0] k);
    @(negedge clk);
    rst = 1'b1;
    key = k;
    @(negedge clk);
    chk(ready == 1'b0, "R1 ready low in reset", 128'(ready), 128'd0);
    @(negedge clk);
    rst = 1'b0;
  endtask

  // Count 40 edges; optionally swap the key input part-way (R6)
  task automatic wait_expand(input int swap_at, input logic [127:0] k2);
    for (int c = 1; c <= 40; c++) begin
      @(negedge clk);
      if (c == swap_at) key = k2;
      if (c == 39) chk(ready == 1'b0, "R1 ready low at cycle 39", 128'(ready), 128'd0);
      if (c == 40) chk(ready == 1'b1, "R1 ready high at cycle 40", 128'(ready), 128'd1);
    end
  endtask

  // R4/R5/R8: sweep every index without a clock edge between reads
  task automatic check_all(input logic [127:0] k, input string tag);
    for (int r = 0; r < 16; r++) begin
      rd_idx = 4'(r);
      #0.2;
      if (r <= 10) chk(rd_key === ref_round(k, r), {tag, " R4 R8 round key"}, rd_key, ref_round(k, r));
      else         chk(rd_key === '0, {tag, " R5 out-of-range index"}, rd_key, '0);
    end
    rd_idx = 4'd0;
  endtask

  initial begin
    #1_000_000;
    if (!finished) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [127:0] std_key;
    logic [127:0] k1, k2;
    int           cut;

    build_sbox();
    void'($urandom(32'd20240611));
    std_key = 128'h2b7e151628aed2a6abf7158809cf4f3c;

    // Reset state
    repeat (3) @(negedge clk);
    chk(ready == 1'b0, "R1 reset state", 128'(ready), 128'd0);

    // Standard vector
    start(std_key);
    wait_expand(0, '0);
    rd_idx = 4'd0;  #0.2;
    chk(rd_key === std_key, "R3 round 0 equals key", rd_key, std_key);
    rd_idx = 4'd1;  #0.2;
    chk(rd_key === 128'ha0fafe1788542cb123a339392a6c7605, "R4 standard round 1",
        rd_key, 128'ha0fafe1788542cb123a339392a6c7605);
    rd_idx = 4'd10; #0.2;
    chk(rd_key === 128'hd014f9a8c9ee2589e13f0cc8b6630ca6, "R4 standard round 10",
        rd_key, 128'hd014f9a8c9ee2589e13f0cc8b6630ca6);
    check_all(std_key, "std");

    // R2: idle with key input wiggling; ready and keys must hold
    for (int c = 0; c < 50; c++) begin
      @(negedge clk);
      key = {$urandom, $urandom, $urandom, $urandom};
    end
    chk(ready == 1'b1, "R2 ready sticky", 128'(ready), 128'd1);
    check_all(std_key, "R2 hold");

    // Directed extremes
    start('0);
    wait_expand(0, '0);
    check_all('0, "zero key");
    start('1);
    wait_expand(0, '0);
    check_all('1, "ones key");

    // R6: key changed during expansion is ignored
    k1 = {$urandom, $urandom, $urandom, $urandom};
    k2 = ~k1;
    start(k1);
    wait_expand(7, k2);
    check_all(k1, "R6 key swap ignored");

    // R7: reset part-way through, restart with the new key
    for (int t = 0; t < 4; t++) begin
      k1  = {$urandom, $urandom, $urandom, $urandom};
      k2  = {$urandom, $urandom, $urandom, $urandom};
      cut = 1 + int'($urandom % 38);
      start(k1);
      repeat (cut) @(negedge clk);
      start(k2);
      chk(ready == 1'b0, "R7 ready cleared after reset", 128'(ready), 128'd0);
      wait_expand(0, '0);
      check_all(k2, "R7 restart");
    end

    // R7: reset after completion, inverse-order walk (10 down to 0)
    k1 = {$urandom, $urandom, $urandom, $urandom};
    start(k1);
    chk(ready == 1'b0, "R7 ready cleared from done", 128'(ready), 128'd0);
    wait_expand(0, '0);
    for (int r = 10; r >= 0; r--) begin
      rd_idx = 4'(r);
      #0.2;
      chk(rd_key === ref_round(k1, r), "R8 reverse walk", rd_key, ref_round(k1, r));
    end

    // Random keys
    for (int t = 0; t < 12; t++) begin
      k1 = {$urandom, $urandom, $urandom, $urandom};
      start(k1);
      wait_expand(0, '0);
      check_all(k1, "random");
    end

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule